// File: doc/BRIEF.md
# Two-Operand NaN Propagation Selector

This block sits behind a two-input floating-point operation once that operation has found at least one NaN among its operands. It decides which operand becomes the NaN result and forces that result quiet. It also raises the invalid-operation flag whenever either operand is a signaling NaN. The operation itself detects that NaN handling is needed. This block classifies both operands on its own.

The selection rule is picked per operation by a two-bit mode input. One rule takes a signaling operand first. One rule takes the first NaN operand. The third compares magnitudes: a quiet NaN beats a signaling one, and between two NaNs of the same kind the larger significand wins, with a sign-based final tie-break. A default-NaN enable replaces the selected value with one fixed canonical NaN. The result, the flag and a valid bit leave the block through a single register stage. The operand format is set by the exponent and fraction width parameters.

Top module: `nan_prop_select`

## Requirements
- R1: An operand is a NaN when its exponent field (the EXP_W bits below the sign bit) is all ones and its fraction field (the low FRAC_W bits) is nonzero. A NaN whose fraction MSB is 1 is quiet, and one whose fraction MSB is 0 is signaling. An all-ones exponent with a zero fraction is an infinity and is not a NaN.
- R2: When dflt_nan_en is 1, the result is the canonical NaN for any operands and any mode. The canonical NaN has sign 0, an all-ones exponent and a fraction with only its MSB set (0x7FC00000 at the default widths).
- R3: out_invalid is 1 exactly when op_a or op_b is a signaling NaN. This holds in every mode, with or without dflt_nan_en.
- R4: rule_mode 0 (signaling first) picks the first match from this list: a if signaling, b if signaling, a if quiet NaN, otherwise b.
- R5: rule_mode 1 (first NaN) picks a if a is any NaN, otherwise b.
- R6: rule_mode 2 (magnitude rule) picks the quiet operand when one operand is signaling and the other quiet. It picks the NaN when only one operand is a NaN, and b when neither is.
- R7: In rule_mode 2, when both operands are NaNs of the same kind, the one whose value without the sign bit is larger as an unsigned number is picked.
- R8: In rule_mode 2, when both operands are NaNs of the same kind and their values without the sign bit are equal, a is picked if its full word is below b's full word as unsigned (a positive, b negative). Otherwise b is picked.
- R9: rule_mode 3 behaves exactly as rule_mode 0.
- R10: The picked operand leaves with its fraction MSB forced to 1 and every other bit unchanged, so the result is never a signaling NaN.
- R11: out_valid, out_result and out_invalid reflect the inputs sampled at the clock edge where in_valid was 1, and appear one cycle after that edge.
- R12: While rst is 1, out_valid and out_invalid are 0 and out_result is 0.
- R13: After a cycle with in_valid 0, out_valid and out_invalid are 0 and out_result keeps its previous value.
- R14: In rule_mode 0 and rule_mode 1 the magnitude comparison has no effect. For two quiet NaNs where b has the larger magnitude, a is still picked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| op_a | input | EXP_W+FRAC_W+1 | First operand |
| op_b | input | EXP_W+FRAC_W+1 | Second operand |
| rule_mode | input | 2 | Selection rule: 0 signaling first, 1 first NaN, 2 magnitude rule, 3 same as 0 |
| dflt_nan_en | input | 1 | Force the canonical NaN as result |
| out_valid | output | 1 | Registered result is valid |
| out_result | output | EXP_W+FRAC_W+1 | Selected and silenced NaN, or the canonical NaN |
| out_invalid | output | 1 | Invalid-operation flag for the registered result |

## Verification
Two functions can act on the same operation: the canonical-NaN override and the invalid flag. With dflt_nan_en set, the result no longer depends on the operands, but the flag still must. The bench sends signaling operands in every mode with the override enabled. It checks that each such operation gives the canonical NaN together with a raised flag, and that the flag stays low when neither operand is signaling. Random mixes of quiet, signaling, infinite and finite operands run with the override toggled at random. Directed pairs with equal magnitudes and opposite signs target the tie-break.

// File: rtl/nanp_pkg.sv
package nanp_pkg;

  typedef enum logic [1:0] {
    RULE_SIG_FIRST = 2'd0,
    RULE_NAN_FIRST = 2'd1,
    RULE_MAGNITUDE = 2'd2,
    RULE_ALIAS     = 2'd3
  } rule_e;

  typedef struct packed {
    logic is_nan;
    logic is_quiet;
    logic is_sig;
  } nan_class_t;

endpackage

// File: rtl/nanp_classify.sv
module nanp_classify
  import nanp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W = EXP_W + FRAC_W + 1
) (
  input  logic [W-1:0] op,
  output nan_class_t   cls
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_ones;
  logic              frac_nz;

  assign exp_f    = op[W-2:FRAC_W];
  assign frac_f   = op[FRAC_W-1:0];
  assign exp_ones = &exp_f;
  assign frac_nz  = |frac_f;

  always_comb begin
    cls.is_nan   = exp_ones & frac_nz;
    cls.is_quiet = exp_ones & frac_f[FRAC_W-1];
    cls.is_sig   = exp_ones & frac_nz & ~frac_f[FRAC_W-1];
  end
endmodule

// File: rtl/nanp_magcmp.sv
module nanp_magcmp #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic         a_larger
);
  logic [W-2:0] mag_a;
  logic [W-2:0] mag_b;

  assign mag_a = a[W-2:0];
  assign mag_b = b[W-2:0];

  always_comb begin
    if (mag_a != mag_b) a_larger = (mag_a > mag_b);
    else                a_larger = (a < b);
  end
endmodule

// File: rtl/nanp_pick.sv
module nanp_pick
  import nanp_pkg::*;
(
  input  nan_class_t cls_a,
  input  nan_class_t cls_b,
  input  rule_e      rule,
  input  logic       a_larger,
  output logic       pick_b
);
  logic pick_sig_first;
  logic pick_nan_first;
  logic pick_mag;

  assign pick_sig_first = cls_a.is_sig   ? 1'b0 :
                          cls_b.is_sig   ? 1'b1 :
                          cls_a.is_quiet ? 1'b0 : 1'b1;

  assign pick_nan_first = ~cls_a.is_nan;

  always_comb begin
    if (cls_a.is_sig) begin
      if (cls_b.is_sig) pick_mag = ~a_larger;
      else              pick_mag = cls_b.is_quiet;
    end else if (cls_a.is_quiet) begin
      if (cls_b.is_quiet) pick_mag = ~a_larger;
      else                pick_mag = 1'b0;
    end else begin
      pick_mag = 1'b1;
    end
  end

  always_comb begin
    unique case (rule)
      RULE_NAN_FIRST: pick_b = pick_nan_first;
      RULE_MAGNITUDE: pick_b = pick_mag;
      default:        pick_b = pick_sig_first;
    endcase
  end
endmodule

// File: rtl/nan_prop_select.sv
module nan_prop_select
  import nanp_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W = EXP_W + FRAC_W + 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [1:0]   rule_mode,
  input  logic         dflt_nan_en,
  output logic         out_valid,
  output logic [W-1:0] out_result,
  output logic         out_invalid
);
  localparam logic [W-1:0] QBIT_MASK = W'(1) << (FRAC_W - 1);
  localparam logic [W-1:0] CANON_NAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [W-1:0] ops [2];
  nan_class_t   cls [2];
  logic         a_larger;
  logic         pick_b;
  logic [W-1:0] chosen;
  logic         chosen_sig;
  logic [W-1:0] quieted;
  logic [W-1:0] next_result;
  logic         next_invalid;

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar gi = 0; gi < 2; gi++) begin : g_cls
    nanp_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op  (ops[gi]),
      .cls (cls[gi])
    );
  end

  nanp_magcmp #(.W(W)) u_mag (
    .a        (op_a),
    .b        (op_b),
    .a_larger (a_larger)
  );

  nanp_pick u_pick (
    .cls_a    (cls[0]),
    .cls_b    (cls[1]),
    .rule     (rule_e'(rule_mode)),
    .a_larger (a_larger),
    .pick_b   (pick_b)
  );

  assign chosen       = pick_b ? op_b : op_a;
  assign chosen_sig   = pick_b ? cls[1].is_sig : cls[0].is_sig;
  assign quieted      = chosen_sig ? (chosen | QBIT_MASK) : chosen;
  assign next_result  = dflt_nan_en ? CANON_NAN : quieted;
  assign next_invalid = cls[0].is_sig | cls[1].is_sig;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_invalid <= 1'b0;
      out_result  <= '0;
    end else begin
      out_valid   <= in_valid;
      out_invalid <= in_valid & next_invalid;
      if (in_valid) out_result <= next_result;
    end
  end

  // Checks on the registered stage
  logic out_is_snan;
  assign out_is_snan = (&out_result[W-2:FRAC_W]) & (|out_result[FRAC_W-2:0])
                       & ~out_result[FRAC_W-1];

  a_r2_default_nan: assert property (@(posedge clk) disable iff (rst)
    in_valid && dflt_nan_en |=> out_result == CANON_NAN);

  a_r3_invalid_raised: assert property (@(posedge clk) disable iff (rst)
    in_valid && (cls[0].is_sig || cls[1].is_sig) |=> out_invalid);

  a_r3_invalid_only_valid: assert property (@(posedge clk) disable iff (rst)
    out_invalid |-> out_valid);

  a_r5_first_nan: assert property (@(posedge clk) disable iff (rst)
    in_valid && !dflt_nan_en && rule_mode == 2'd1 && cls[0].is_nan
    |=> out_result == ($past(op_a) | QBIT_MASK));

  a_r10_never_signaling: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_is_snan);

  a_r13_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(out_result) && !out_valid);

endmodule

// File: tb/nan_prop_select_bench.sv
module nan_prop_select_bench;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int W = EXP_W + FRAC_W + 1;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [W-1:0] op_a, op_b;
  logic [1:0]   rule_mode;
  logic         dflt_nan_en;
  logic         out_valid;
  logic [W-1:0] out_result;
  logic         out_invalid;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  nan_prop_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nan_prop_select (
    .clk, .rst, .in_valid, .op_a, .op_b, .rule_mode, .dflt_nan_en,
    .out_valid, .out_result, .out_invalid
  );

  // Reference model built from the requirements
  function automatic bit m_nan(input logic [W-1:0] v);
    return (v[30:23] == 8'hFF) && (v[22:0] != 23'd0);
  endfunction
  function automatic bit m_q(input logic [W-1:0] v);
    return m_nan(v) && v[22];
  endfunction
  function automatic bit m_s(input logic [W-1:0] v);
    return m_nan(v) && !v[22];
  endfunction

  function automatic logic [W-1:0] ref_result(input logic [W-1:0] a, input logic [W-1:0] b,
                                              input logic [1:0] md, input bit dn);
    bit take_b;
    bit a_big;
    logic [W-1:0] c;
    if (dn) return 32'h7FC00000;
    if (a[30:0] != b[30:0]) a_big = a[30:0] > b[30:0];
    else                    a_big = a < b;
    if (md == 2'd1) take_b = !m_nan(a);
    else if (md == 2'd2) begin
      if (m_nan(a) && m_nan(b)) begin
        if (m_s(a) == m_s(b)) take_b = !a_big;
        else                  take_b = m_s(a);
      end else take_b = !m_nan(a);
    end else begin
      if (m_s(a))      take_b = 1'b0;
      else if (m_s(b)) take_b = 1'b1;
      else if (m_q(a)) take_b = 1'b0;
      else             take_b = 1'b1;
    end
    c = take_b ? b : a;
    if (m_s(c)) c[22] = 1'b1;
    return c;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] md, input bit dn);
    if (dn) return "R2";
    case (md)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6/R7/R8";
      default: return "R9";
    endcase
  endfunction

  // One operation: drive at a falling edge, check at the next falling edge
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic [1:0] md, input bit dn, input string tag);
    logic [W-1:0] exp_r;
    exp_r = ref_result(a, b, md, dn);
    @(negedge clk);
    op_a = a; op_b = b; rule_mode = md; dflt_nan_en = dn; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11 out_valid", {31'd0, out_valid}, 32'd1);
    check(tag, out_result, exp_r);
    check("R3 invalid", {31'd0, out_invalid}, {31'd0, m_s(a) | m_s(b)});
    check("R10 quiet out", {31'd0, m_s(out_result)}, 32'd0);
  endtask

  function automatic logic [W-1:0] rnd_op(input int kind);
    logic [W-1:0] v;
    v = $urandom;
    case (kind)
      0: if (v[30:23] == 8'hFF) v[30:23] = 8'h7E;
      1: begin v[30:23] = 8'hFF; v[22] = 1'b1; end
      2: begin v[30:23] = 8'hFF; v[22] = 1'b0; if (v[21:0] == 22'd0) v[0] = 1'b1; end
      default: begin v[30:23] = 8'hFF; v[22:0] = 23'd0; end
    endcase
    return v;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] held;
    void'($urandom(32'd5150));
    rst = 1'b1; in_valid = 1'b0; op_a = '0; op_b = '0; rule_mode = 2'd0; dflt_nan_en = 1'b0;
    repeat (3) @(negedge clk);
    // R12 reset state
    check("R12 valid", {31'd0, out_valid}, 32'd0);
    check("R12 invalid", {31'd0, out_invalid}, 32'd0);
    check("R12 result", out_result, 32'd0);
    rst = 1'b0;

    // R1 classification: infinity is not a NaN, quiet/signaling by fraction MSB
    run_op(32'h7F800000, 32'hFFC00001, 2'd0, 1'b0, "R1 inf vs qnan");
    check("R1 inf picked nan", out_result, 32'hFFC00001);
    run_op(32'h7F800001, 32'h3F800000, 2'd0, 1'b0, "R1 snan detect");
    check("R1 snan silenced", out_result, 32'h7FC00001);
    // R4 order
    run_op(32'h7FC00005, 32'h7F800007, 2'd0, 1'b0, "R4 b signaling");
    check("R4 b chosen", out_result, 32'h7FC00007);
    // R5 first NaN even if b signaling
    run_op(32'h7FC00005, 32'h7F800007, 2'd1, 1'b0, "R5 a quiet first");
    check("R5 a chosen", out_result, 32'h7FC00005);
    // R6 signaling + quiet gives quiet
    run_op(32'h7F800009, 32'hFFC00002, 2'd2, 1'b0, "R6 quiet wins");
    check("R6 b chosen", out_result, 32'hFFC00002);
    // R7 larger significand
    run_op(32'hFFC00001, 32'h7FC00100, 2'd2, 1'b0, "R7 larger b");
    check("R7 b chosen", out_result, 32'h7FC00100);
    // R8 tie: equal magnitude, positive one wins (either order)
    run_op(32'hFFC00033, 32'h7FC00033, 2'd2, 1'b0, "R8 tie b positive");
    check("R8 positive b", out_result, 32'h7FC00033);
    run_op(32'h7F800033, 32'hFF800033, 2'd2, 1'b0, "R8 tie a positive");
    check("R8 positive a", out_result, 32'h7FC00033);
    // R14 magnitude ignored outside mode 2
    run_op(32'h7FC00001, 32'h7FC00100, 2'd0, 1'b0, "R14 mode0");
    check("R14 mode0 a", out_result, 32'h7FC00001);
    run_op(32'h7FC00001, 32'h7FC00100, 2'd1, 1'b0, "R14 mode1");
    check("R14 mode1 a", out_result, 32'h7FC00001);
    // R9 alias mode
    run_op(32'h7FC00005, 32'h7F800007, 2'd3, 1'b0, "R9 alias");
    check("R9 b chosen", out_result, 32'h7FC00007);
    // R2 with R3 in the same cycle
    run_op(32'hFF800011, 32'h7FC00000, 2'd2, 1'b1, "R2 default with snan");
    check("R3 invalid under default", {31'd0, out_invalid}, 32'd1);
    // R13 hold
    held = out_result;
    @(negedge clk);
    check("R13 hold result", out_result, held);
    check("R13 valid low", {31'd0, out_valid}, 32'd0);
    check("R13 invalid low", {31'd0, out_invalid}, 32'd0);

    // Random mix
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra, rb;
      logic [1:0] md;
      bit dn;
      ra = rnd_op(int'($urandom % 4));
      rb = rnd_op(int'($urandom % 4));
      if (($urandom % 6) == 0) rb = {~ra[31], ra[30:0]};
      md = 2'($urandom);
      dn = (($urandom % 4) == 0);
      run_op(ra, rb, md, dn, mode_tag(md, dn));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule